// File: doc/BRIEF.md
# Serial Transmitter with Programmable Bit-Rate Divider

This block turns bytes written by a host into an asynchronous serial stream. A 16-bit divider turns the system clock into a tick enable that runs at sixteen times the bit rate. Every bit on the line lasts a whole number of these ticks. Written bytes wait in a 16-entry queue. A serializer takes them one at a time and frames each one: a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period of one, one-and-a-half or two bit times.

The serializer samples the framing settings when it takes a byte from the queue. A setting changed during a frame therefore applies only from the next frame. A break input pulls the line low at any time. It does not pause the serializer, so any frame sent during a break is lost. Status outputs report when the queue is full, when it is empty, and when the whole transmitter has gone quiet.

Top module: `uart_tx_core`

## Requirements
- R1: The divider emits one tick every `divisor_i` clock cycles, with any value from 1 to 65535 accepted. A value of 0 stops the ticks and freezes the frame in progress. A change of value restarts the count from zero.
- R2: The queue holds 16 bytes. `fifo_full_o` is high when 16 bytes are stored. A write made while the queue is full is dropped. `fifo_empty_o` is high when no byte is stored.
- R3: `wlen_i` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are sent least significant bit first.
- R4: `parity_i` set to 01 adds an odd parity bit. Set to 10, it adds an even parity bit. Set to 00 or 11, no parity bit is sent. The parity bit covers only the data bits that are sent.
- R5: `stop_i` set to 00 gives 16 stop ticks and 10 or 11 gives 32 stop ticks. Set to 01, it gives 24 ticks with 5-bit characters and 32 ticks with any other length.
- R6: The line is high when idle. The start bit is low. Start, data and parity bits each last 16 ticks. A frame starts on the clock after the byte is taken from the queue, without waiting for a tick.
- R7: While `break_i` is high, `txd_o` is low. Serialization goes on underneath, so frames sent during the break are lost rather than delayed.
- R8: `tx_empty_o` is high only when the queue is empty and no frame is in progress, including its final stop tick.
- R9: Word length, parity and stop settings are captured when a byte leaves the queue. A change during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Byte to queue |
| divisor_i | input | 16 | Clocks per oversample tick (0 = stopped) |
| wlen_i | input | 2 | Data bit count select |
| parity_i | input | 2 | Parity mode select |
| stop_i | input | 2 | Stop length select |
| break_i | input | 1 | Force line low |
| txd_o | output | 1 | Serial line |
| fifo_full_o | output | 1 | Queue holds 16 bytes |
| fifo_empty_o | output | 1 | Queue holds no byte |
| tx_empty_o | output | 1 | Queue empty and serializer idle |

## Verification
The assertions check on every cycle that the serializer state moves only on a tick, that an idle serializer with nothing queued stays idle, that a full queue with no read stays full, and that a tick is never followed at once by another tick when the divider is above one. Only the bench's scenarios can show that the bit lengths are right for each word length, parity and stop setting. The same holds for dropping the 17th write, freezing a frame with a zero divisor, a break that loses data, and settings captured per frame. For these, the bench compares the line and the flags on every cycle against a tick-level model.

// File: rtl/txc_pkg.sv
package txc_pkg;
   localparam int unsigned CHAR_W = 8;

   typedef enum logic [1:0] {
      PAR_NONE     = 2'd0,
      PAR_ODD      = 2'd1,
      PAR_EVEN     = 2'd2,
      PAR_NONE_ALT = 2'd3
   } par_mode_e;

   typedef enum logic [1:0] {
      STOP_ONE      = 2'd0,
      STOP_ONE_HALF = 2'd1,
      STOP_TWO      = 2'd2,
      STOP_TWO_ALT  = 2'd3
   } stop_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP
   } tx_state_e;
endpackage

// File: rtl/txc_baud_gen.sv
module txc_baud_gen #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   if (DIV_W < 2) begin : g_bad_width
      $error("txc_baud_gen: DIV_W must be at least 2");
   end

   assign tick_o = (div_q != '0) && (cnt_q == div_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (divisor_i != div_q) begin
         div_q <= divisor_i;
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && div_q != 1 && divisor_i == div_q) |=> !tick_o);
endmodule

// File: rtl/txc_fifo.sv
module txc_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic             rd_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic             full_o,
   output logic             empty_o
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("txc_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0]      wptr_q;
   logic [AW:0]      rptr_q;
   logic             wr_ok;
   logic             rd_ok;

   assign empty_o   = (wptr_q == rptr_q);
   assign full_o    = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
   assign wr_ok     = wr_i && !full_o;
   assign rd_ok     = rd_i && !empty_o;
   assign rd_data_o = mem[rptr_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr_q[AW-1:0]] <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else begin
         if (wr_ok) wptr_q <= wptr_q + 1'b1;
         if (rd_ok) rptr_q <= rptr_q + 1'b1;
      end
   end

   // R2
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !rd_i) |=> full_o);
   // R2
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && !wr_i) |=> empty_o);
endmodule

// File: rtl/txc_serializer.sv
module txc_serializer
   import txc_pkg::*;
#(
   parameter int unsigned OS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              avail_i,
   input  logic [CHAR_W-1:0] data_i,
   input  logic [1:0]        wlen_i,
   input  par_mode_e         par_i,
   input  stop_mode_e        stop_i,
   output logic              pop_o,
   output logic              line_o,
   output logic              idle_o
);
   localparam int unsigned TW = $clog2(2 * OS);

   if (OS < 2 || (OS % 2) != 0) begin : g_bad_os
      $error("txc_serializer: OS must be even and at least 2");
   end

   tx_state_e         state_q;
   logic [TW-1:0]     tcnt_q;
   logic [2:0]        bidx_q;
   logic [2:0]        blast_q;
   logic [CHAR_W-1:0] shreg_q;
   logic              par_en_q;
   logic              par_bit_q;
   logic [TW-1:0]     stop_last_q;
   logic [TW-1:0]     stop_last_d;
   logic [CHAR_W-1:0] mask;
   logic              ones;
   logic              bit_end;

   for (genvar gi = 0; gi < CHAR_W; gi++) begin : g_mask
      assign mask[gi] = (4'(gi) < (4'd5 + {2'b00, wlen_i}));
   end

   assign ones    = ^(data_i & mask);
   assign bit_end = tick_i && (tcnt_q == TW'(OS - 1));
   assign pop_o   = (state_q == ST_IDLE) && avail_i;
   assign idle_o  = (state_q == ST_IDLE);

   always_comb begin
      unique case (stop_i)
         STOP_ONE:      stop_last_d = TW'(OS - 1);
         STOP_ONE_HALF: stop_last_d = (wlen_i == 2'd0) ? TW'(OS + OS / 2 - 1) : TW'(2 * OS - 1);
         default:       stop_last_d = TW'(2 * OS - 1);
      endcase
   end

   always_comb begin
      unique case (state_q)
         ST_START:  line_o = 1'b0;
         ST_DATA:   line_o = shreg_q[0];
         ST_PARITY: line_o = par_bit_q;
         default:   line_o = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         tcnt_q      <= '0;
         bidx_q      <= '0;
         blast_q     <= '0;
         shreg_q     <= '0;
         par_en_q    <= 1'b0;
         par_bit_q   <= 1'b0;
         stop_last_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (avail_i) begin
               state_q     <= ST_START;
               tcnt_q      <= '0;
               shreg_q     <= data_i;
               blast_q     <= 3'd4 + {1'b0, wlen_i};
               par_en_q    <= (par_i == PAR_ODD) || (par_i == PAR_EVEN);
               par_bit_q   <= (par_i == PAR_ODD) ? ~ones : ones;
               stop_last_q <= stop_last_d;
            end
            ST_START: if (tick_i) begin
               if (bit_end) begin
                  tcnt_q  <= '0;
                  bidx_q  <= '0;
                  state_q <= ST_DATA;
               end else tcnt_q <= tcnt_q + 1'b1;
            end
            ST_DATA: if (tick_i) begin
               if (bit_end) begin
                  tcnt_q  <= '0;
                  shreg_q <= shreg_q >> 1;
                  if (bidx_q == blast_q) state_q <= par_en_q ? ST_PARITY : ST_STOP;
                  else bidx_q <= bidx_q + 1'b1;
               end else tcnt_q <= tcnt_q + 1'b1;
            end
            ST_PARITY: if (tick_i) begin
               if (bit_end) begin
                  tcnt_q  <= '0;
                  state_q <= ST_STOP;
               end else tcnt_q <= tcnt_q + 1'b1;
            end
            ST_STOP: if (tick_i) begin
               if (tcnt_q == stop_last_q) begin
                  tcnt_q  <= '0;
                  state_q <= ST_IDLE;
               end else tcnt_q <= tcnt_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R6
   state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && state_q != ST_IDLE) |=> $stable(state_q));
   // R6
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_o |=> (state_q == ST_START && !line_o));
   // R8
   idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && !avail_i) |=> idle_o);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
   import txc_pkg::*;
#(
   parameter int unsigned DIV_W      = 16,
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned OS         = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [CHAR_W-1:0] wr_data_i,
   input  logic [DIV_W-1:0]  divisor_i,
   input  logic [1:0]        wlen_i,
   input  logic [1:0]        parity_i,
   input  logic [1:0]        stop_i,
   input  logic              break_i,
   output logic              txd_o,
   output logic              fifo_full_o,
   output logic              fifo_empty_o,
   output logic              tx_empty_o
);
   logic              tick;
   logic              pop;
   logic              line;
   logic              ser_idle;
   logic [CHAR_W-1:0] head;

   txc_baud_gen #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .divisor_i(divisor_i), .tick_o(tick)
   );

   txc_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_en_i), .wr_data_i(wr_data_i),
      .rd_i(pop), .rd_data_o(head), .full_o(fifo_full_o), .empty_o(fifo_empty_o)
   );

   txc_serializer #(.OS(OS)) u_ser (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .avail_i(!fifo_empty_o),
      .data_i(head), .wlen_i(wlen_i), .par_i(par_mode_e'(parity_i)),
      .stop_i(stop_mode_e'(stop_i)), .pop_o(pop), .line_o(line), .idle_o(ser_idle)
   );

   assign txd_o      = line & ~break_i;
   assign tx_empty_o = fifo_empty_o & ser_idle;

   // R8
   busy_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !tx_empty_o);
endmodule

// File: tb/uart_tx_core_tb_top.sv
module uart_tx_core_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [15:0] divisor = '0;
   logic [1:0] wlen = 2'd3;
   logic [1:0] parity = 2'd0;
   logic [1:0] stop = 2'd0;
   logic       brk = 1'b0;
   logic       txd, full, empty, tx_empty;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_tx_core dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .divisor_i(divisor), .wlen_i(wlen), .parity_i(parity), .stop_i(stop),
      .break_i(brk), .txd_o(txd), .fifo_full_o(full), .fifo_empty_o(empty),
      .tx_empty_o(tx_empty)
   );

   // behavioural model: queued bytes, and one line level per pending tick
   byte unsigned mq[$];
   bit           lv[$];
   int           m_cnt = 0;
   int           m_div = 0;
   bit           m_tk;
   bit           m_full;

   task automatic push_n(bit v, int n);
      for (int k = 0; k < n; k++) lv.push_back(v);
   endtask

   task automatic build(byte unsigned d);
      int nb = 5 + int'(wlen);
      int ones = 0;
      int st;
      push_n(1'b0, 16);
      for (int i = 0; i < nb; i++) begin
         push_n(d[i], 16);
         ones += d[i];
      end
      if (parity == 2'd1) push_n(((ones % 2) == 0), 16);
      if (parity == 2'd2) push_n(((ones % 2) == 1), 16);
      if (stop == 2'd0) st = 16;
      else if (stop == 2'd1 && nb == 5) st = 24;
      else st = 32;
      push_n(1'b1, st);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete();
         lv.delete();
         m_cnt = 0;
         m_div = 0;
      end else begin
         m_tk   = (m_div != 0) && (m_cnt == m_div - 1);
         m_full = (mq.size() == 16);
         if (lv.size() != 0) begin
            if (m_tk) void'(lv.pop_front());
         end else if (mq.size() != 0) begin
            build(mq.pop_front());
         end
         if (wr_en && !m_full) mq.push_back(wr_data);
         if (int'(divisor) != m_div) begin
            m_div = int'(divisor);
            m_cnt = 0;
         end else if (m_tk) m_cnt = 0;
         else m_cnt = m_cnt + 1;
      end
   end

   task automatic chk(string tag, bit ok, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compared on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e_txd;
         e_txd = brk ? 1'b0 : ((lv.size() != 0) ? lv[0] : 1'b1);
         chk("R6 line level", txd == e_txd, int'(txd), int'(e_txd));
         chk("R2 full flag", full == (mq.size() == 16), int'(full), int'(mq.size() == 16));
         chk("R2 empty flag", empty == (mq.size() == 0), int'(empty), int'(mq.size() == 0));
         chk("R8 tx_empty", tx_empty == (mq.size() == 0 && lv.size() == 0),
             int'(tx_empty), int'(mq.size() == 0 && lv.size() == 0));
      end
   end

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic put(byte unsigned d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         if (tx_empty) break;
      end
      cyc(2);
   endtask

   task automatic summary();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
   end

   initial begin
      cyc(4);
      rst_n = 1'b1;
      cyc(1);
      @(negedge clk);
      chk("R8 reset tx_empty", tx_empty == 1'b1, int'(tx_empty), 1);
      chk("R6 reset idle high", txd == 1'b1, int'(txd), 1);
      chk("R2 reset empty", empty == 1'b1 && full == 1'b0, int'(full), 0);

      // R3 8 bits, no parity, one stop (R5)
      divisor = 16'd1; wlen = 2'd3; parity = 2'd0; stop = 2'd0;
      put(8'hA5);
      wait_idle();
      // R4 even parity, R5 one-and-a-half with 5 bits
      wlen = 2'd0; parity = 2'd2; stop = 2'd1;
      put(8'h13); put(8'h1F);
      wait_idle();
      // R5 one-and-a-half with 6 bits gives two; R4 odd
      wlen = 2'd1; parity = 2'd1; stop = 2'd1;
      put(8'h2C);
      wait_idle();
      // R3 7 bits, parity code 11 means none, two stops
      wlen = 2'd2; parity = 2'd3; stop = 2'd2;
      put(8'h5A);
      wait_idle();

      // R2 fill past depth, divisor 3 (R1)
      divisor = 16'd3; wlen = 2'd3; parity = 2'd2; stop = 2'd3;
      @(posedge clk); #1;
      for (int i = 0; i < 18; i++) begin
         wr_en = 1'b1; wr_data = 8'(8'h30 + i);
         @(posedge clk); #1;
      end
      wr_en = 1'b0;
      @(negedge clk);
      chk("R2 full after overfill", full == 1'b1, int'(full), 1);
      wait_idle();

      // R7 break mid-frame
      divisor = 16'd2; wlen = 2'd3; parity = 2'd0; stop = 2'd0;
      put(8'hFF);
      cyc(40);
      brk = 1'b1;
      @(negedge clk);
      chk("R7 break forces low", txd == 1'b0, int'(txd), 0);
      cyc(200);
      brk = 1'b0;
      wait_idle();

      // R1 zero divisor freezes a frame
      divisor = 16'd0;
      put(8'h81);
      cyc(80);
      @(negedge clk);
      chk("R1 frozen start bit", txd == 1'b0, int'(txd), 0);
      chk("R1 frozen not empty", tx_empty == 1'b0, int'(tx_empty), 0);
      divisor = 16'd2;
      cyc(33);
      divisor = 16'd5;
      wait_idle();

      // R9 settings changed mid-frame apply to the next frame only
      divisor = 16'd1; wlen = 2'd3; parity = 2'd0; stop = 2'd0;
      put(8'hC3); put(8'h3C);
      cyc(30);
      wlen = 2'd0; parity = 2'd1; stop = 2'd1;
      wait_idle();
      @(negedge clk);
      chk("R9 done", tx_empty == 1'b1, int'(tx_empty), 1);
      summary();
   end
endmodule